// File: doc/BRIEF.md
# Port Loopback Selector with Alarm Substitution

This block sits at one port between the system-side framer and the line interface. It switches the two serial directions among four loopback arrangements. In the first, transmit data returns to the receive path near the line. In the second, the received line signal is sent straight back out to the line. In the third, the framer's transmit stream feeds its own receive input. In the fourth, the received payload is turned back toward the line. When a loopback cuts a direction off from its normal source, that direction can carry an all-ones alarm pattern instead. On the line side, the block can also raise a request so that a downstream framer formats a framed DS3 alarm.

Each direction carries a data word of `DATA_W` bits and a clock enable that marks a valid bit. The four loopback enables and three alarm options are plain control inputs. They are captured into an internal mode register, and only at a bit boundary, so a bit in flight never changes source halfway through. Illegal enable combinations are resolved by a fixed priority. The single allowed pair, line loopback together with framer diagnostic loopback, is kept as a pair.

Top module: `lb_selector`

## Requirements
- R1: With no loopback in effect, line_tx_data/line_tx_en equal sys_tx_data/sys_tx_en and sys_rx_data/sys_rx_en equal line_rx_data/line_rx_en in the same cycle. ds3_ais_req is 0.
- R2: Control inputs are captured only at a rising clock edge where sys_tx_en or line_rx_en is 1. At other edges the previous mode and options hold. After reset no loopback is in effect and all options are 0.
- R3: In analog loopback, sys_rx carries sys_tx (data and enable). line_tx also carries sys_tx.
- R4: In line loopback, line_tx carries line_rx (data and enable). sys_rx carries line_rx data, or all ones when cfg_llb_ais was 1, with line_rx_en as its enable.
- R5: In diagnostic loopback alone, sys_rx carries sys_tx. line_tx_data is all ones and line_tx_en follows sys_tx_en. ds3_ais_req equals the captured cfg_ds3_ais.
- R6: In payload loopback, line_tx carries line_rx. sys_rx carries line_rx data, or all ones when cfg_plb_ais was 1, with line_rx_en as its enable.
- R7: With line and diagnostic loopback both enabled, both take effect. line_tx carries line_rx, sys_rx carries sys_tx, and ds3_ais_req is 0.
- R8: Any other combination of several enables keeps only the highest one in the order diagnostic, line, payload, analog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_alb | input | 1 | Request analog-side loopback (transmit to receive) |
| cfg_llb | input | 1 | Request line loopback (receive to transmit at line) |
| cfg_dlb | input | 1 | Request framer diagnostic loopback |
| cfg_plb | input | 1 | Request payload loopback |
| cfg_llb_ais | input | 1 | All ones toward system during line loopback |
| cfg_plb_ais | input | 1 | All ones toward system during payload loopback |
| cfg_ds3_ais | input | 1 | Ask for framed DS3 alarm on line side during diagnostic loopback |
| sys_tx_data | input | DATA_W | Framer transmit data |
| sys_tx_en | input | 1 | Framer transmit bit enable |
| sys_rx_data | output | DATA_W | Data toward framer receive |
| sys_rx_en | output | 1 | Bit enable toward framer receive |
| line_rx_data | input | DATA_W | Data from line receiver |
| line_rx_en | input | 1 | Line receive bit enable |
| line_tx_data | output | DATA_W | Data toward line transmitter |
| line_tx_en | output | 1 | Bit enable toward line transmitter |
| ds3_ais_req | output | 1 | Request for framed DS3 alarm on line side |

## Verification
The bench builds the block with `DATA_W` set to 2. With two bits, the patterns 01 and 10 are distinct from the all-ones substitute and from each other. A swapped source, a dropped alarm or a passthrough in the wrong direction therefore shows up as a different word. Each mode is checked with opposite enable values on the two sides, so an enable taken from the wrong direction also shows. The capture rule is tested by changing the controls while both enables are low and confirming that the old mode is still in effect.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef struct packed {
    logic dlb;
    logic llb;
    logic plb;
    logic alb;
  } lb_mode_t;

  typedef struct packed {
    logic llb_ais;
    logic plb_ais;
    logic ds3_sel;
  } lb_opt_t;

  localparam lb_mode_t LB_PAIR = '{dlb: 1'b1, llb: 1'b1, plb: 1'b0, alb: 1'b0};

  // Keep the permitted pair, otherwise the single highest request wins.
  function automatic lb_mode_t lb_resolve(lb_mode_t req);
    lb_mode_t m;
    m = '0;
    if (req.dlb) begin
      m.dlb = 1'b1;
      m.llb = req.llb;
    end else if (req.llb) begin
      m.llb = 1'b1;
    end else if (req.plb) begin
      m.plb = 1'b1;
    end else if (req.alb) begin
      m.alb = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lb_mode_reg.sv
module lb_mode_reg
  import lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  lb_mode_t req,
  input  lb_opt_t  req_opt,
  output lb_mode_t mode,
  output lb_opt_t  opt
);

  lb_mode_t mode_next;
  assign mode_next = lb_resolve(req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      opt  <= '0;
    end else if (upd) begin
      mode <= mode_next;
      opt  <= req_opt;
    end
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(mode) && $stable(opt)));

  // R8
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode) <= 1) || (mode == LB_PAIR));

endmodule

// File: rtl/lb_line_mux.sv
module lb_line_mux #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_llb,
  input  logic              m_plb,
  input  logic              m_dlb,
  input  logic              ds3_sel,
  input  logic [DATA_W-1:0] sys_tx_data,
  input  logic              sys_tx_en,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_en,
  output logic [DATA_W-1:0] line_tx_data,
  output logic              line_tx_en,
  output logic              ais_req
);

  localparam logic [DATA_W-1:0] ONES = '1;

  always_comb begin
    ais_req = 1'b0;
    if (m_llb || m_plb) begin
      line_tx_data = line_rx_data;
      line_tx_en   = line_rx_en;
    end else if (m_dlb) begin
      line_tx_data = ONES;
      line_tx_en   = sys_tx_en;
      ais_req      = ds3_sel;
    end else begin
      line_tx_data = sys_tx_data;
      line_tx_en   = sys_tx_en;
    end
  end

  // R5
  ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ais_req |-> (line_tx_data == ONES));

  // R7
  pair_no_ais_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_llb && m_dlb) |-> (!ais_req && line_tx_en == line_rx_en));

endmodule

// File: rtl/lb_sys_mux.sv
module lb_sys_mux #(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_dlb,
  input  logic              m_alb,
  input  logic              m_llb,
  input  logic              m_plb,
  input  logic              llb_ais,
  input  logic              plb_ais,
  input  logic [DATA_W-1:0] sys_tx_data,
  input  logic              sys_tx_en,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_en,
  output logic [DATA_W-1:0] sys_rx_data,
  output logic              sys_rx_en
);

  localparam logic [DATA_W-1:0] ONES = '1;
  logic blank;

  assign blank = (m_llb && llb_ais) || (m_plb && plb_ais);

  always_comb begin
    if (m_dlb || m_alb) begin
      sys_rx_data = sys_tx_data;
      sys_rx_en   = sys_tx_en;
    end else begin
      sys_rx_data = blank ? ONES : line_rx_data;
      sys_rx_en   = line_rx_en;
    end
  end

  // R3
  local_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_dlb || m_alb) |-> (sys_rx_en == sys_tx_en && sys_rx_data == sys_tx_data));

endmodule

// File: rtl/lb_selector.sv
module lb_selector
  import lb_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_alb,
  input  logic              cfg_llb,
  input  logic              cfg_dlb,
  input  logic              cfg_plb,
  input  logic              cfg_llb_ais,
  input  logic              cfg_plb_ais,
  input  logic              cfg_ds3_ais,
  input  logic [DATA_W-1:0] sys_tx_data,
  input  logic              sys_tx_en,
  output logic [DATA_W-1:0] sys_rx_data,
  output logic              sys_rx_en,
  input  logic [DATA_W-1:0] line_rx_data,
  input  logic              line_rx_en,
  output logic [DATA_W-1:0] line_tx_data,
  output logic              line_tx_en,
  output logic              ds3_ais_req
);

  lb_mode_t req, mode;
  lb_opt_t  req_opt, opt;
  logic     bit_edge;

  assign req      = '{dlb: cfg_dlb, llb: cfg_llb, plb: cfg_plb, alb: cfg_alb};
  assign req_opt  = '{llb_ais: cfg_llb_ais, plb_ais: cfg_plb_ais, ds3_sel: cfg_ds3_ais};
  assign bit_edge = sys_tx_en | line_rx_en;

  lb_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .upd(bit_edge),
    .req(req), .req_opt(req_opt), .mode(mode), .opt(opt)
  );

  lb_line_mux #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .m_llb(mode.llb), .m_plb(mode.plb), .m_dlb(mode.dlb), .ds3_sel(opt.ds3_sel),
    .sys_tx_data(sys_tx_data), .sys_tx_en(sys_tx_en),
    .line_rx_data(line_rx_data), .line_rx_en(line_rx_en),
    .line_tx_data(line_tx_data), .line_tx_en(line_tx_en), .ais_req(ds3_ais_req)
  );

  lb_sys_mux #(.DATA_W(DATA_W)) u_sys (
    .clk(clk), .rst_n(rst_n),
    .m_dlb(mode.dlb), .m_alb(mode.alb), .m_llb(mode.llb), .m_plb(mode.plb),
    .llb_ais(opt.llb_ais), .plb_ais(opt.plb_ais),
    .sys_tx_data(sys_tx_data), .sys_tx_en(sys_tx_en),
    .line_rx_data(line_rx_data), .line_rx_en(line_rx_en),
    .sys_rx_data(sys_rx_data), .sys_rx_en(sys_rx_en)
  );

  // R1
  straight_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0) |-> (line_tx_data == sys_tx_data && sys_rx_data == line_rx_data
                      && !ds3_ais_req));

endmodule

// File: tb/lb_selector_tb_top.sv
`timescale 1ns/1ps
module lb_selector_tb_top;

  localparam int DW = 2;
  localparam int OW = 2*DW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_alb = 0, c_llb = 0, c_dlb = 0, c_plb = 0;
  logic c_lais = 0, c_pais = 0, c_ds3 = 0;
  logic [DW-1:0] st_d = '0, lr_d = '0;
  logic st_e = 0, lr_e = 0;
  logic [DW-1:0] sr_d, lt_d;
  logic sr_e, lt_e, req_o;

  // applied (captured) state as the bench sees it
  logic a_alb = 0, a_llb = 0, a_dlb = 0, a_plb = 0;
  logic a_lais = 0, a_pais = 0, a_ds3 = 0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lb_selector #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_alb(c_alb), .cfg_llb(c_llb), .cfg_dlb(c_dlb), .cfg_plb(c_plb),
    .cfg_llb_ais(c_lais), .cfg_plb_ais(c_pais), .cfg_ds3_ais(c_ds3),
    .sys_tx_data(st_d), .sys_tx_en(st_e), .sys_rx_data(sr_d), .sys_rx_en(sr_e),
    .line_rx_data(lr_d), .line_rx_en(lr_e), .line_tx_data(lt_d), .line_tx_en(lt_e),
    .ds3_ais_req(req_o)
  );

  function automatic logic [OW-1:0] model(input logic [DW-1:0] s, input logic se,
                                          input logic [DW-1:0] r, input logic re);
    logic ed, el, ep, ea;
    logic [DW-1:0] ltd, srd;
    logic lte, sre, rq;
    {ed, el, ep, ea} = 4'b0000;
    casez ({a_dlb, a_llb, a_plb, a_alb})
      4'b11??: {ed, el} = 2'b11;
      4'b10??: ed = 1'b1;
      4'b01??: el = 1'b1;
      4'b001?: ep = 1'b1;
      4'b0001: ea = 1'b1;
      default: ;
    endcase
    rq = 1'b0;
    if (el || ep)      begin ltd = r;  lte = re; end
    else if (ed)       begin ltd = '1; lte = se; rq = a_ds3; end
    else               begin ltd = s;  lte = se; end
    if (ed || ea)      begin srd = s;  sre = se; end
    else if (el)       begin srd = a_lais ? '1 : r; sre = re; end
    else if (ep)       begin srd = a_pais ? '1 : r; sre = re; end
    else               begin srd = r;  sre = re; end
    return {ltd, lte, srd, sre, rq};
  endfunction

  task automatic check_io(input string rq, input bit quiet);
    logic [DW-1:0] sp [3] = '{2'b01, 2'b10, 2'b00};
    logic [DW-1:0] lp [3] = '{2'b10, 2'b01, 2'b11};
    for (int k = 0; k < 3; k++) begin
      logic [OW-1:0] exp_v, act_v;
      @(negedge clk);
      st_d = sp[k]; lr_d = lp[k];
      st_e = quiet ? 1'b0 : k[0];
      lr_e = quiet ? 1'b0 : ~k[0];
      #1;
      exp_v = model(st_d, st_e, lr_d, lr_e);
      act_v = {lt_d, lt_e, sr_d, sr_e, req_o};
      n_chk++;
      if (act_v !== exp_v) begin
        n_bad++;
        $display("FAIL %s pattern %0d actual=%h expected=%h", rq, k, act_v, exp_v);
      end
    end
    @(negedge clk);
    st_e = 1'b0; lr_e = 1'b0;
  endtask

  task automatic apply(input logic a, l, d, p, la, pa, ds);
    @(negedge clk);
    {c_alb, c_llb, c_dlb, c_plb, c_lais, c_pais, c_ds3} = {a, l, d, p, la, pa, ds};
    st_e = 1'b1;
    @(negedge clk);
    st_e = 1'b0;
    {a_alb, a_llb, a_dlb, a_plb, a_lais, a_pais, a_ds3} = {a, l, d, p, la, pa, ds};
  endtask

  task automatic t_reset();
    // R2: reset state is straight through
    check_io("R2 reset", 1'b1);
  endtask

  task automatic t_passthru();
    apply(0, 0, 0, 0, 1, 1, 1);
    check_io("R1 straight", 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    c_llb = 1'b1; c_lais = 1'b1;
    repeat (3) @(negedge clk);
    check_io("R2 hold", 1'b1);
    apply(0, 1, 0, 0, 1, 0, 0);
    check_io("R2 capture", 1'b0);
  endtask

  task automatic t_alb();
    apply(1, 0, 0, 0, 0, 0, 0);
    check_io("R3 analog", 1'b0);
  endtask

  task automatic t_llb();
    apply(0, 1, 0, 0, 0, 0, 0);
    check_io("R4 line", 1'b0);
    apply(0, 1, 0, 0, 1, 0, 0);
    check_io("R4 line ais", 1'b0);
  endtask

  task automatic t_dlb();
    apply(0, 0, 1, 0, 0, 0, 0);
    check_io("R5 diag raw", 1'b0);
    apply(0, 0, 1, 0, 0, 0, 1);
    check_io("R5 diag ds3", 1'b0);
  endtask

  task automatic t_plb();
    apply(0, 0, 0, 1, 0, 0, 0);
    check_io("R6 payload", 1'b0);
    apply(0, 0, 0, 1, 0, 1, 0);
    check_io("R6 payload ais", 1'b0);
  endtask

  task automatic t_pair();
    apply(0, 1, 1, 0, 1, 0, 1);
    check_io("R7 pair", 1'b0);
  endtask

  task automatic t_priority();
    apply(0, 1, 0, 1, 0, 1, 0);
    check_io("R8 line over payload", 1'b0);
    apply(1, 0, 0, 1, 0, 1, 0);
    check_io("R8 payload over analog", 1'b0);
    apply(1, 0, 1, 1, 0, 1, 1);
    check_io("R8 diag over rest", 1'b0);
    apply(1, 1, 0, 1, 0, 1, 0);
    check_io("R8 line over all", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_hold();
    t_alb();
    t_llb();
    t_dlb();
    t_plb();
    t_pair();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule